// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block keeps the interrupt enable bits and the pending-interrupt flags for a group of three timer/counters. The counters, comparators and pin drivers live elsewhere. They report compare matches, overflows and input captures as one-cycle event pulses. Two of those events come from a timer that runs on its own clock. The unit carries them into the processor clock domain with a toggle handshake, so an event is never dropped.

On the processor side there is one 8-bit register port. A select input picks the enable register or the flag register. A write to the enable register stores the data. A write to the flag register clears every flag whose data bit is one. A global enable input gates every request. When several enabled flags are pending, the request output presents the one with the lowest bit index as the vector number. An acknowledge pulse clears only that flag.

Top module: `tirq_unit`

## Requirements
- R1: A one on `sync_evt_i[j]` at a clock edge sets flag bit j+2 at that edge. The flag layout is: bit 7 timer2 compare, bit 6 timer2 overflow, bit 5 timer1 capture, bit 4 timer1 compare A, bit 3 timer1 compare B, bit 2 timer1 overflow, bit 1 async-timer compare, bit 0 async-timer overflow.
- R2: When `ack_i` is high while `irq_o` is high, the flag at index `irq_vec_o` is cleared at that edge and every other flag is kept. When `irq_o` is low, `ack_i` has no effect.
- R3: A write with `reg_sel_i`=1 clears each flag whose data bit is one. Flags whose data bit is zero keep their value.
- R4: `irq_o` is high only when `gie_i` is high and at least one bit is one in both the enable register and the flag register.
- R5: After reset, the enable register, the flag register and `irq_o` are all zero.
- R6: Among the pending enabled flags, `irq_vec_o` gives the lowest bit index.
- R7: A write with `reg_sel_i`=0 loads the enable register with `reg_wdata_i`. `reg_rdata_o` returns the enable register when `reg_sel_i`=0 and the flag register when `reg_sel_i`=1.
- R8: An async-timer event sampled at a `tclk_i` rising edge is visible in the flag register after the third `clk` rising edge that follows it, and not after the second.
- R9: If a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends at one.
- R10: With `async_pwm_i`=0, the async-timer overflow flag (bit 0) is set by `async_wrap_i` and `async_bottom_i` is ignored. With `async_pwm_i`=1, bit 0 is set by `async_bottom_i` and `async_wrap_i` is ignored.
- R11: An async event that arrives while the previous crossing is still in progress is held back and delivered afterwards, so it is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| tclk_i | input | 1 | Clock of the asynchronous timer |
| async_evt_i | input | 2 | Async timer events in the `tclk_i` domain: bit 1 compare, bit 0 counter wrap |
| async_bottom_i | input | 1 | Async timer direction reversal at zero, in the `tclk_i` domain |
| async_pwm_i | input | 1 | Async timer is in phase-correct PWM mode |
| sync_evt_i | input | 6 | Synchronous timer events; bit j sets flag j+2 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = enable register, 1 = flag register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Vector acknowledge |
| irq_o | output | 1 | Interrupt request |
| irq_vec_o | output | 3 | Bit index of the granted flag |

## Verification
Several properties are checked on every cycle. A flag only rises after a set event. A set always wins over a clear. Write-one clears a flag and write-zero keeps it. An acknowledge clears the granted flag. The grant is at most one-hot. A request always points at an enabled, pending flag. The crossing never emits two pulses back to back. Other behaviours only show up in the bench scenarios: the exact three-clock latency of the async path, the selection between wrap and bottom events in PWM mode, delivery of an event held back during a busy crossing, and the ordering of the vector number across different enable patterns.

// File: rtl/tirq_pkg.sv
`timescale 1ns/1ps
package tirq_pkg;
    localparam int FLAGS_DEF = 8;
    localparam int ASYNC_DEF = 2;
    // flag positions decoded by the vector number
    localparam int POS_A_OVF  = 0;
    localparam int POS_A_CMP  = 1;
    localparam int POS_T1_OVF = 2;
    localparam int POS_T2_CMP = 7;
endpackage

// File: rtl/tirq_async_bridge.sv
`timescale 1ns/1ps
module tirq_async_bridge #(
    parameter int NA = tirq_pkg::ASYNC_DEF
) (
    input  logic          clk,
    input  logic          tclk,
    input  logic          rst_n,
    input  logic [NA-1:0] evt_t_i,
    input  logic          bottom_t_i,
    input  logic          pwm_t_i,
    output logic [NA-1:0] pulse_o
);
    typedef struct packed {
        logic [NA-1:0] req;
        logic [NA-1:0] pend;
        logic [NA-1:0] ack_s1;
        logic [NA-1:0] ack_s2;
    } tside_t;

    typedef struct packed {
        logic [NA-1:0] s1;
        logic [NA-1:0] s2;
        logic [NA-1:0] s3;
    } cside_t;

    tside_t t_d, t_q;
    cside_t c_d, c_q;
    logic [NA-1:0] ev;

    // timer clock side: toggle request, hold back events while busy
    always_comb begin
        t_d = t_q;
        ev  = evt_t_i;
        if (pwm_t_i) ev[tirq_pkg::POS_A_OVF] = bottom_t_i;
        for (int i = 0; i < NA; i++) begin
            if ((t_q.req[i] == t_q.ack_s2[i]) && (ev[i] || t_q.pend[i])) begin
                t_d.req[i]  = ~t_q.req[i];
                t_d.pend[i] = 1'b0;
            end else if (ev[i]) begin
                t_d.pend[i] = 1'b1;
            end
        end
        t_d.ack_s1 = c_q.s3;
        t_d.ack_s2 = t_q.ack_s1;
    end

    always_ff @(posedge tclk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // processor clock side: two-stage synchronizer plus edge stage
    always_comb begin
        c_d    = c_q;
        c_d.s1 = t_q.req;
        c_d.s2 = c_q.s1;
        c_d.s3 = c_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pulse_o = c_q.s2 ^ c_q.s3;

    for (genvar g = 0; g < NA; g++) begin : g_chk
        AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_o[g] |=> !pulse_o[g]); // R11
    end
endmodule

// File: rtl/tirq_flag_bank.sv
`timescale 1ns/1ps
module tirq_flag_bank #(
    parameter int N = tirq_pkg::FLAGS_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         wr_i,
    input  logic         sel_i,
    input  logic [N-1:0] wdata_i,
    input  logic [N-1:0] ack_clr_i,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] mask;
        logic [N-1:0] flag;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [N-1:0] clr;

    always_comb begin
        bank_d = bank_q;
        if (wr_i && !sel_i) bank_d.mask = wdata_i;
        clr = ack_clr_i;
        if (wr_i && sel_i) clr = clr | wdata_i;
        bank_d.flag = (bank_q.flag & ~clr) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign mask_o = bank_q.mask;
    assign flag_o = bank_q.flag;

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_o[g]) |-> $past(set_i[g])); // R1
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_o[g]); // R9
        AST_WR1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && sel_i && wdata_i[g] && !set_i[g]) |=> !flag_o[g]); // R3
        AST_WR0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && sel_i && !wdata_i[g] && !ack_clr_i[g] && flag_o[g]) |=> flag_o[g]); // R3
    end
endmodule

// File: rtl/tirq_prio.sv
`timescale 1ns/1ps
module tirq_prio #(
    parameter int N  = tirq_pkg::FLAGS_DEF,
    parameter int VW = $clog2(N)
) (
    input  logic [N-1:0]  flag_i,
    input  logic [N-1:0]  mask_i,
    input  logic          gie_i,
    output logic [N-1:0]  grant_o,
    output logic          irq_o,
    output logic [VW-1:0] vec_o
);
    logic [N-1:0] pend;

    always_comb begin
        pend    = flag_i & mask_i & {N{gie_i}};
        grant_o = '0;
        vec_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                vec_o      = VW'(i);
            end
        end
        irq_o = |pend;
    end

    always_comb begin
        AST_GRANT_ONEHOT: assert ($onehot0(grant_o)); // R6
    end
endmodule

// File: rtl/tirq_unit.sv
`timescale 1ns/1ps
module tirq_unit #(
    parameter int NUM_FLAGS = tirq_pkg::FLAGS_DEF,
    parameter int NUM_ASYNC = tirq_pkg::ASYNC_DEF,
    localparam int VEC_W  = $clog2(NUM_FLAGS),
    localparam int NUM_SYNC = NUM_FLAGS - NUM_ASYNC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tclk_i,
    input  logic [NUM_ASYNC-1:0] async_evt_i,
    input  logic                 async_bottom_i,
    input  logic                 async_pwm_i,
    input  logic [NUM_SYNC-1:0]  sync_evt_i,
    input  logic                 reg_wr_i,
    input  logic                 reg_sel_i,
    input  logic [NUM_FLAGS-1:0] reg_wdata_i,
    output logic [NUM_FLAGS-1:0] reg_rdata_o,
    input  logic                 gie_i,
    input  logic                 ack_i,
    output logic                 irq_o,
    output logic [VEC_W-1:0]     irq_vec_o
);
    logic [NUM_ASYNC-1:0] async_pulse;
    logic [NUM_FLAGS-1:0] set_all, ack_clr, grant, mask_q, flag_q;

    tirq_async_bridge #(.NA(NUM_ASYNC)) u_bridge (
        .clk        (clk),
        .tclk       (tclk_i),
        .rst_n      (rst_n),
        .evt_t_i    (async_evt_i),
        .bottom_t_i (async_bottom_i),
        .pwm_t_i    (async_pwm_i),
        .pulse_o    (async_pulse)
    );

    assign set_all = {sync_evt_i, async_pulse};
    assign ack_clr = grant & {NUM_FLAGS{ack_i}};

    tirq_flag_bank #(.N(NUM_FLAGS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_all),
        .wr_i      (reg_wr_i),
        .sel_i     (reg_sel_i),
        .wdata_i   (reg_wdata_i),
        .ack_clr_i (ack_clr),
        .mask_o    (mask_q),
        .flag_o    (flag_q)
    );

    tirq_prio #(.N(NUM_FLAGS), .VW(VEC_W)) u_prio (
        .flag_i  (flag_q),
        .mask_i  (mask_q),
        .gie_i   (gie_i),
        .grant_o (grant),
        .irq_o   (irq_o),
        .vec_o   (irq_vec_o)
    );

    assign reg_rdata_o = reg_sel_i ? flag_q : mask_q;

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !set_all[irq_vec_o]) |=> !flag_q[$past(irq_vec_o)]); // R2
    AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (gie_i && flag_q[irq_vec_o] && mask_q[irq_vec_o])); // R4
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (flag_q == '0 && mask_q == '0)); // R5
endmodule

// File: tb/tirq_unit_tb.sv
`timescale 1ns/1ps
module tirq_unit_tb;
    logic       clk = 1'b0, tclk = 1'b0, rst_n = 1'b0;
    logic [1:0] a_evt = '0;
    logic       a_bot = 1'b0, a_pwm = 1'b0;
    logic [5:0] s_evt = '0;
    logic       wr = 1'b0, sel = 1'b0, gie = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic       irq;
    logic [2:0] vec;

    always #2.5 clk = ~clk;   // 200 MHz
    always #7   tclk = ~tclk; // unrelated timer clock

    tirq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .tclk_i(tclk), .async_evt_i(a_evt),
        .async_bottom_i(a_bot), .async_pwm_i(a_pwm), .sync_evt_i(s_evt),
        .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .gie_i(gie), .ack_i(ack), .irq_o(irq), .irq_vec_o(vec)
    );

    typedef struct {
        string      tag;
        logic [7:0] exp;
        logic [7:0] act;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_checks = 0, n_errors = 0;
    bit done = 1'b0;

    // driver side: push an expected item with the value seen now
    task automatic expect_val(input string tag, input logic [7:0] exp, input logic [7:0] act);
        sb_item_t it;
        it.tag = tag; it.exp = exp; it.act = act;
        sb_q.push_back(it);
    endtask

    // monitor: pops and compares
    initial begin
        forever begin
            sb_item_t it;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            n_checks++;
            if (it.act !== it.exp) begin
                n_errors++;
                $display("FAIL %s: actual %0h expected %0h", it.tag, it.act, it.exp);
            end
        end
    end

    function automatic logic [7:0] rd(input logic s);
        return s ? u_dut.reg_rdata_o : 8'h00;
    endfunction

    task automatic read_reg(input logic s, output logic [7:0] v);
        sel = s;
        #0.5;
        v = rdata;
    endtask

    task automatic write_reg(input logic s, input logic [7:0] d);
        sel = s; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic sync_pulse(input logic [5:0] e);
        s_evt = e;
        @(negedge clk);
        s_evt = '0;
    endtask

    task automatic async_pulse(input logic [1:0] e, input logic bot);
        @(negedge tclk);
        a_evt = e; a_bot = bot;
        @(negedge tclk);
        a_evt = '0; a_bot = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 reset state
        read_reg(1'b0, v); expect_val("R5 mask after reset", 8'h00, v);
        read_reg(1'b1, v); expect_val("R5 flags after reset", 8'h00, v);
        expect_val("R5 irq after reset", 8'h00, {7'd0, irq});

        // R7 enable register load and readback
        write_reg(1'b0, 8'hA5);
        read_reg(1'b0, v); expect_val("R7 mask readback", 8'hA5, v);
        write_reg(1'b0, 8'hFF);

        // R1 synchronous events
        sync_pulse(6'b000001);
        read_reg(1'b1, v); expect_val("R1 timer1 overflow -> bit2", 8'h04, v);
        sync_pulse(6'b100000);
        read_reg(1'b1, v); expect_val("R1 timer2 compare -> bit7", 8'h84, v);

        // R4 gating by global enable and mask
        expect_val("R4 irq low with gie=0", 8'h00, {7'd0, irq});
        gie = 1'b1; #0.5;
        expect_val("R4 irq high with gie=1", 8'h01, {7'd0, irq});
        expect_val("R6 lowest index wins", 8'h02, {5'd0, vec});
        write_reg(1'b0, 8'h80); #0.5;
        expect_val("R6 only bit7 enabled", 8'h07, {5'd0, vec});
        write_reg(1'b0, 8'h00); #0.5;
        expect_val("R4 irq low with mask zero", 8'h00, {7'd0, irq});
        write_reg(1'b0, 8'hFF);

        // R2 acknowledge clears only the granted flag
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        read_reg(1'b1, v); expect_val("R2 ack clears bit2 only", 8'h80, v);
        gie = 1'b0;
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        read_reg(1'b1, v); expect_val("R2 ack without request ignored", 8'h80, v);

        // R3 write-one clear
        write_reg(1'b1, 8'h00);
        read_reg(1'b1, v); expect_val("R3 write zero keeps", 8'h80, v);
        write_reg(1'b1, 8'h7F);
        read_reg(1'b1, v); expect_val("R3 other ones keep bit7", 8'h80, v);
        write_reg(1'b1, 8'h80);
        read_reg(1'b1, v); expect_val("R3 write one clears", 8'h00, v);

        // R9 set beats write-one clear
        s_evt = 6'b001000; sel = 1'b1; wdata = 8'h20; wr = 1'b1;
        @(negedge clk);
        s_evt = '0; wr = 1'b0; wdata = '0;
        read_reg(1'b1, v); expect_val("R9 set wins over write-one", 8'h20, v);
        // R9 set beats acknowledge
        gie = 1'b1; #0.5;
        expect_val("R6 vector 5 pending", 8'h05, {5'd0, vec});
        s_evt = 6'b001000; ack = 1'b1;
        @(negedge clk);
        s_evt = '0; ack = 1'b0;
        read_reg(1'b1, v); expect_val("R9 set wins over ack", 8'h20, v);
        gie = 1'b0;
        write_reg(1'b1, 8'hFF);

        // R8 async latency: three clk edges after the sampling tclk edge
        sel = 1'b1;
        @(negedge tclk);
        a_evt = 2'b10;
        @(posedge tclk);
        fork begin #1; a_evt = '0; end join_none
        @(posedge clk); @(posedge clk); @(negedge clk);
        expect_val("R8 not visible after two edges", 8'h00, rdata & 8'h02);
        @(posedge clk); @(negedge clk);
        expect_val("R8 visible after third edge", 8'h02, rdata & 8'h02);
        repeat (12) @(negedge clk);
        write_reg(1'b1, 8'hFF);

        // R10 overflow source selection
        async_pulse(2'b00, 1'b1);
        @(negedge clk); read_reg(1'b1, v);
        expect_val("R10 bottom ignored outside PWM", 8'h00, v);
        async_pulse(2'b01, 1'b0);
        @(negedge clk); read_reg(1'b1, v);
        expect_val("R10 wrap sets bit0 outside PWM", 8'h01, v);
        write_reg(1'b1, 8'hFF);
        a_pwm = 1'b1;
        async_pulse(2'b01, 1'b0);
        @(negedge clk); read_reg(1'b1, v);
        expect_val("R10 wrap ignored in PWM", 8'h00, v);
        async_pulse(2'b00, 1'b1);
        @(negedge clk); read_reg(1'b1, v);
        expect_val("R10 bottom sets bit0 in PWM", 8'h01, v);
        write_reg(1'b1, 8'hFF);
        a_pwm = 1'b0;

        // R11 back-to-back async events during a busy crossing
        @(negedge tclk); a_evt = 2'b10;
        @(negedge tclk); @(negedge tclk); a_evt = '0;
        @(negedge clk);
        sel = 1'b1;
        for (int k = 0; k < 40; k++) begin
            if (rdata[1]) break;
            @(negedge clk);
        end
        expect_val("R11 first event delivered", 8'h02, rdata & 8'h02);
        write_reg(1'b1, 8'h02);
        read_reg(1'b1, v); expect_val("R11 cleared before second arrives", 8'h00, v & 8'h02);
        repeat (30) @(negedge clk);
        read_reg(1'b1, v); expect_val("R11 held-back event delivered", 8'h02, v & 8'h02);
        read_reg(1'b0, v); expect_val("R7 mask untouched by flag traffic", 8'hFF, v);

        wait (sb_q.size() == 0);
        #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule